// File: doc/BRIEF.md
# Endpoint-Zero Transfer Control Register

This block is the meeting point between an 8-bit CPU bus and a low-speed USB device engine. It serves endpoint zero and two interrupt endpoints. Its central piece is one byte-wide control register. The low nibble holds a transfer-type code and the high nibble holds a byte count. The engine and the software both use that code as a shared mailbox. The engine posts "SETUP arrived" or "OUT arrived" into it. Software posts "acknowledged", "send IN data" or "stall" into it. An eight-byte data bank sits beside the register. It holds the payload in both directions.

Packet bytes from the engine arrive on a valid/ready stream. The block raises `rx_ready` only while the type field is empty. The engine holds its bytes back for as long as `rx_ready` is low, and meanwhile answers the host with NAK. It can see that state on `ep_busy`. Outgoing IN data leaves on a second valid/ready stream. Once `tx_valid` is high, `tx_data`, `tx_last` and `tx_zlp` stay stable until `tx_ready` is seen high at a clock edge. The CPU reads the register with combinational read data. A read of the control byte clears any pending packet interrupt.

Top module: `ep0_ctl_reg`

## Requirements
- R1: After reset the control byte reads 8'h00. Both interrupt requests, `ep_stall`, `ep_busy`, `tx_valid` and `tx_done` are low, and `rx_ready` is high.
- R2: The control byte sits at CPU address 8. Bits 3:0 hold the type code (0=empty, 1=reserved, 2=SETUP, 3=OUT, 4=stall, 5=IN). Bits 7:4 hold the length.
- R3: A received packet whose last beat carries `rx_is_setup`=1 has these effects. Its bytes go into bank addresses 0, 1, 2 … in order. The type becomes 2 and the length becomes the byte count. `irq_setup` rises and stays high.
- R4: A packet whose last beat has `rx_is_setup`=0 is stored the same way. The type becomes 3 and `irq_out` rises.
- R5: A CPU read of the control byte returns the current value. It also clears both interrupt requests and leaves the type and length unchanged.
- R6: While the type is not 0, `rx_ready` is low and `ep_busy` is high, and the bank is not written by the engine.
- R7: A CPU write of type 0 empties the field and restores `rx_ready`.
- R8: A CPU write of type 4 drives `ep_stall` high and blocks reception until type 0 is written.
- R9: A CPU write of type 5 with length N (N>0) streams bank bytes 0 to N-1 in order. `tx_last` is high on byte N-1, and the outputs hold steady while `tx_ready` is low.
- R10: On the final IN handshake, the type returns to 0 and the length is kept. `tx_done` pulses high for exactly one cycle.
- R11: Arming IN with length 0 produces one beat with `tx_zlp` and `tx_last` high.
- R12: A CPU write to the control byte with any type code other than 0, 4 or 5 is ignored as a whole.
- R13: A written length above 8 is stored as 8. A received packet longer than 8 bytes keeps its first 8 bytes and reports length 8.
- R14: CPU addresses 0 to 7 read and write the data bank directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 4 | CPU register address (0-7 bank, 8 control) |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe (clears interrupts on control read) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| irq_setup | output | 1 | SETUP interrupt request |
| irq_out | output | 1 | OUT interrupt request |
| rx_valid | input | 1 | Engine packet byte valid |
| rx_ready | output | 1 | Block can accept a packet byte |
| rx_data | input | 8 | Engine packet byte |
| rx_last | input | 1 | Final byte of the packet |
| rx_is_setup | input | 1 | Packet is a SETUP (sampled on last beat) |
| tx_valid | output | 1 | IN byte valid |
| tx_ready | input | 1 | Engine takes the IN byte |
| tx_data | output | 8 | IN byte |
| tx_last | output | 1 | Final IN beat |
| tx_zlp | output | 1 | Beat is a zero-length packet marker |
| tx_done | output | 1 | One-cycle pulse after the IN packet completes |
| ep_stall | output | 1 | All endpoints stalled |
| ep_busy | output | 1 | Mailbox occupied; engine must NAK |

## Verification
The assertions rely on a few promises about the inputs. The CPU never issues a control write in the same cycle that a received packet ends or an IN packet completes. It leaves the data bank alone while an IN transfer is armed. The engine asserts `rx_last` only together with `rx_valid`. The directed stimulus keeps to all of these rules in three ways. It issues every command only after the stream it affects has gone idle. It loads the bank before arming IN. It drives stream beats on the falling edge with `rx_last` set on just the final beat.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  typedef enum logic [3:0] {
    XT_EMPTY = 4'h0,
    XT_RSVD  = 4'h1,
    XT_SETUP = 4'h2,
    XT_OUT   = 4'h3,
    XT_STALL = 4'h4,
    XT_IN    = 4'h5
  } xfer_t;

  localparam int TYPE_W = 4;
endpackage

// File: rtl/ep0_bank.sv
module ep0_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_wdata,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data
);
  logic [DW-1:0] mem [DEPTH];

  // one register per entry; engine writes win over CPU writes
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (eng_we && eng_addr == AW'(i))
        mem[i] <= eng_wdata;
      else if (cpu_we && cpu_addr == AW'(i))
        mem[i] <= cpu_wdata;
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/ep0_rx_capture.sv
module ep0_rx_capture #(
  parameter int DEPTH = 8,
  parameter int LW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          rx_valid,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          done,
  output logic [LW-1:0] done_len
);
  logic [CW-1:0] cnt;
  logic          full;
  logic          fire;
  logic [CW-1:0] cnt_nxt;

  assign rx_ready = enable;
  assign fire     = rx_valid && rx_ready;
  assign full     = cnt >= CW'(DEPTH);
  assign cnt_nxt  = full ? cnt : cnt + CW'(1);
  assign wr_en    = fire && !full;
  assign wr_addr  = cnt[AW-1:0];
  assign done     = fire && rx_last;
  assign done_len = LW'(cnt_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)
      cnt <= '0;
    else if (done)
      cnt <= '0;
    else if (fire)
      cnt <= cnt_nxt;
  end

  AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R13
endmodule

// File: rtl/ep0_tx_stream.sv
module ep0_tx_stream #(
  parameter int DEPTH = 8,
  parameter int LW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic [LW-1:0] len,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic          tx_last,
  output logic          tx_zlp,
  output logic [AW-1:0] rd_addr,
  output logic          done
);
  logic [AW-1:0] idx;

  assign tx_valid = armed;
  assign tx_zlp   = armed && (len == '0);
  assign tx_last  = armed && ((len == '0) || (LW'(idx) + LW'(1) == len));
  assign rd_addr  = idx;
  assign done     = tx_valid && tx_ready && tx_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !armed)
      idx <= '0;
    else if (tx_valid && tx_ready && !tx_last)
      idx <= idx + AW'(1);
  end
endmodule

// File: rtl/ep0_ctl_reg.sv
module ep0_ctl_reg
  import ep0_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          DEPTH     = 8,
  parameter int          LW        = 4,
  parameter int          CAW       = 4,
  parameter logic [3:0]  CTRL_ADDR = 4'h8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CAW-1:0] cpu_addr,
  input  logic           cpu_wr,
  input  logic           cpu_rd,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  output logic           irq_setup,
  output logic           irq_out,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [DW-1:0]  rx_data,
  input  logic           rx_last,
  input  logic           rx_is_setup,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [DW-1:0]  tx_data,
  output logic           tx_last,
  output logic           tx_zlp,
  output logic           tx_done,
  output logic           ep_stall,
  output logic           ep_busy
);
  localparam int BAW = $clog2(DEPTH);

  xfer_t           xtype;
  logic [LW-1:0]   xlen;

  logic            ctrl_sel, bank_sel;
  logic [TYPE_W-1:0] wcode;
  logic [LW-1:0]   wlen_raw, wlen;
  logic            code_ok, ctrl_wr, bank_wr;

  logic            rx_we, rx_done;
  logic [BAW-1:0]  rx_addr;
  logic [LW-1:0]   rx_len;
  logic [BAW-1:0]  tx_addr;
  logic            tx_fin;
  logic [DW-1:0]   cpu_bank_q;

  // ---------------- CPU decode ----------------
  assign ctrl_sel = cpu_addr == CAW'(CTRL_ADDR);
  assign bank_sel = cpu_addr < CAW'(DEPTH);
  assign wcode    = cpu_wdata[TYPE_W-1:0];
  assign wlen_raw = cpu_wdata[DW-1 -: LW];
  assign wlen     = (wlen_raw > LW'(DEPTH)) ? LW'(DEPTH) : wlen_raw;
  assign code_ok  = (wcode == XT_EMPTY) || (wcode == XT_STALL) || (wcode == XT_IN);
  assign ctrl_wr  = cpu_wr && ctrl_sel && code_ok;
  assign bank_wr  = cpu_wr && bank_sel;

  always_comb begin
    if (ctrl_sel)
      cpu_rdata = {xlen, xtype};
    else if (bank_sel)
      cpu_rdata = cpu_bank_q;
    else
      cpu_rdata = '0;
  end

  // ---------------- sub-blocks ----------------
  ep0_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_we    (rx_we),
    .eng_addr  (rx_addr),
    .eng_wdata (rx_data),
    .cpu_we    (bank_wr),
    .cpu_addr  (cpu_addr[BAW-1:0]),
    .cpu_wdata (cpu_wdata),
    .rd_a_addr (cpu_addr[BAW-1:0]),
    .rd_a_data (cpu_bank_q),
    .rd_b_addr (tx_addr),
    .rd_b_data (tx_data)
  );

  ep0_rx_capture #(.DEPTH(DEPTH), .LW(LW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (xtype == XT_EMPTY),
    .rx_valid (rx_valid),
    .rx_last  (rx_last),
    .rx_ready (rx_ready),
    .wr_en    (rx_we),
    .wr_addr  (rx_addr),
    .done     (rx_done),
    .done_len (rx_len)
  );

  ep0_tx_stream #(.DEPTH(DEPTH), .LW(LW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (xtype == XT_IN),
    .len      (xlen),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .tx_zlp   (tx_zlp),
    .rd_addr  (tx_addr),
    .done     (tx_fin)
  );

  // ---------------- mailbox state ----------------
  // software commands take precedence over engine events
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xtype <= XT_EMPTY;
      xlen  <= '0;
    end else if (ctrl_wr) begin
      xtype <= xfer_t'(wcode);
      xlen  <= wlen;
    end else if (rx_done) begin
      xtype <= rx_is_setup ? XT_SETUP : XT_OUT;
      xlen  <= rx_len;
    end else if (tx_fin) begin
      xtype <= XT_EMPTY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_setup <= 1'b0;
      irq_out   <= 1'b0;
    end else if (rx_done) begin
      if (rx_is_setup) irq_setup <= 1'b1;
      else             irq_out   <= 1'b1;
    end else if (cpu_rd && ctrl_sel) begin
      irq_setup <= 1'b0;
      irq_out   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_done <= 1'b0;
    else        tx_done <= tx_fin;
  end

  assign ep_stall = xtype == XT_STALL;
  assign ep_busy  = xtype != XT_EMPTY;

  // ---------------- assertions ----------------
  AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && ctrl_sel && !rx_done) |=> (!irq_setup && !irq_out)); // R5

  AST_READ_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && ctrl_sel && !cpu_wr && !rx_done && !tx_fin) |=> (xtype == $past(xtype))); // R5

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && ctrl_sel && !code_ok && !rx_done && !tx_fin)
      |=> (xtype == $past(xtype) && xlen == $past(xlen))); // R12

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !cpu_wr)
      |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_zlp))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R10

  AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !$past(ctrl_wr)) |-> (xtype == XT_EMPTY && !tx_valid)); // R10

  AST_BUSY_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    ep_busy |-> !rx_we); // R6

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    xlen <= LW'(DEPTH)); // R13
endmodule

// File: tb/ep0_ctl_reg_bench.sv
module ep0_ctl_reg_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cpu_addr;
  logic       cpu_wr, cpu_rd;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic       irq_setup, irq_out;
  logic       rx_valid, rx_ready, rx_last, rx_is_setup;
  logic [7:0] rx_data;
  logic       tx_valid, tx_ready, tx_last, tx_zlp, tx_done;
  logic [7:0] tx_data;
  logic       ep_stall, ep_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  ep0_ctl_reg u_ep0_ctl_reg (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .irq_setup(irq_setup), .irq_out(irq_out),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_is_setup(rx_is_setup),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_zlp(tx_zlp), .tx_done(tx_done),
    .ep_stall(ep_stall), .ep_busy(ep_busy)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic send_rx(input bit setup, input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = base + 8'(i);
      rx_last = (i == n - 1); rx_is_setup = setup;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // drain an IN packet with alternating back-pressure; bytes expected base+i
  task automatic recv_tx(input string tag, input int nbeats, input logic [7:0] base,
                         input bit zlp);
    int beat = 0;
    int guard = 0;
    bit rdy = 1'b0;
    while (beat < nbeats && guard < 100) begin
      @(negedge clk);
      guard++;
      tx_ready = rdy;
      #1;
      if (!tx_valid) begin
        chk({tag, " valid"}, 8'(tx_valid), 8'd1);
        break;
      end
      if (rdy) begin
        if (!zlp) chk({tag, " data"}, tx_data, base + 8'(beat));
        chk({tag, " last"}, 8'(tx_last), 8'(beat == nbeats - 1));
        chk({tag, " zlp"}, 8'(tx_zlp), 8'(zlp));
        beat++;
      end
      rdy = ~rdy;
    end
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R10 tx_done pulse", 8'(tx_done), 8'd1);
    chk("R10 valid dropped", 8'(tx_valid), 8'd0);
    @(negedge clk);
    chk("R10 tx_done single", 8'(tx_done), 8'd0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R1 irq_setup", 8'(irq_setup), 8'd0);
    chk("R1 irq_out", 8'(irq_out), 8'd0);
    chk("R1 rx_ready", 8'(rx_ready), 8'd1);
    chk("R1 tx_valid", 8'(tx_valid), 8'd0);
    chk("R1 stall/busy", {6'd0, ep_stall, ep_busy}, 8'd0);
    chk("R1 tx_done", 8'(tx_done), 8'd0);
    cpu_read(4'h8, d);
    chk("R1 ctrl reset", d, 8'h00);
  endtask

  task automatic t_setup();
    logic [7:0] d;
    send_rx(1'b1, 8, 8'hA0);
    chk("R3 irq_setup set", 8'(irq_setup), 8'd1);
    chk("R3 irq_out clear", 8'(irq_out), 8'd0);
    cpu_read(4'h8, d);
    chk("R2 R3 ctrl setup", d, 8'h82);
    chk("R5 irq cleared", 8'(irq_setup), 8'd0);
    cpu_read(4'h8, d);
    chk("R5 type kept", d, 8'h82);
    for (int i = 0; i < 8; i++) begin
      cpu_read(4'(i), d);
      chk("R3 bank byte", d, 8'hA0 + 8'(i));
    end
  endtask

  task automatic t_busy();
    logic [7:0] d;
    chk("R6 busy", 8'(ep_busy), 8'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'h55; rx_last = (i == 2); rx_is_setup = 1'b0;
      #1 chk("R6 rx_ready low", 8'(rx_ready), 8'd0);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    cpu_read(4'h0, d);
    chk("R6 bank untouched", d, 8'hA0);
    cpu_read(4'h8, d);
    chk("R6 type untouched", d, 8'h82);
    cpu_write(4'h8, 8'h00);
    cpu_read(4'h8, d);
    chk("R7 acked", d, 8'h00);
    chk("R7 rx_ready back", 8'(rx_ready), 8'd1);
  endtask

  task automatic t_out();
    logic [7:0] d;
    send_rx(1'b0, 3, 8'h11);
    chk("R4 irq_out", 8'(irq_out), 8'd1);
    chk("R4 irq_setup", 8'(irq_setup), 8'd0);
    cpu_read(4'h8, d);
    chk("R4 ctrl out", d, 8'h33);
    chk("R5 irq_out cleared", 8'(irq_out), 8'd0);
    cpu_read(4'h2, d);
    chk("R4 bank2", d, 8'h13);
    cpu_write(4'h8, 8'h00);
  endtask

  task automatic t_long();
    logic [7:0] d;
    send_rx(1'b0, 10, 8'h60);
    cpu_read(4'h8, d);
    chk("R13 long len", d, 8'h83);
    cpu_read(4'h7, d);
    chk("R13 first eight", d, 8'h67);
    cpu_write(4'h8, 8'h00);
  endtask

  task automatic t_bank();
    logic [7:0] d;
    cpu_write(4'h5, 8'h5A);
    cpu_read(4'h5, d);
    chk("R14 bank rw", d, 8'h5A);
  endtask

  task automatic t_in();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) cpu_write(4'(i), 8'hC0 + 8'(i));
    cpu_write(4'h8, 8'h45);
    recv_tx("R9 in", 4, 8'hC0, 1'b0);
    cpu_read(4'h8, d);
    chk("R10 type empty len kept", d, 8'h40);
  endtask

  task automatic t_zlp();
    logic [7:0] d;
    cpu_write(4'h8, 8'h05);
    recv_tx("R11 zlp", 1, 8'h00, 1'b1);
    cpu_read(4'h8, d);
    chk("R11 empty after", d, 8'h00);
  endtask

  task automatic t_stall();
    logic [7:0] d;
    cpu_write(4'h8, 8'h04);
    chk("R8 stall", 8'(ep_stall), 8'd1);
    chk("R8 rx blocked", 8'(rx_ready), 8'd0);
    cpu_read(4'h8, d);
    chk("R8 ctrl stall", d, 8'h04);
    cpu_write(4'h8, 8'h00);
    chk("R8 unstall", 8'(ep_stall), 8'd0);
    chk("R8 rx open", 8'(rx_ready), 8'd1);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    cpu_write(4'h8, 8'h01);
    cpu_write(4'h8, 8'h32);
    cpu_write(4'h8, 8'h23);
    cpu_write(4'h8, 8'h7F);
    cpu_read(4'h8, d);
    chk("R12 ignored", d, 8'h00);
    chk("R12 no busy", 8'(ep_busy), 8'd0);
  endtask

  task automatic t_len_sat();
    logic [7:0] d;
    cpu_write(4'h8, 8'hF0);
    cpu_read(4'h8, d);
    chk("R13 len saturate", d, 8'h80);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0; rx_is_setup = 1'b0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setup();
    t_busy();
    t_out();
    t_long();
    t_bank();
    t_in();
    t_zlp();
    t_stall();
    t_reserved();
    t_len_sat();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule